// File: doc/BRIEF.md
# Interrupt Start Arbiter for NMI and Level Requests

This block decides, at every instruction boundary, whether the core should enter an interrupt response, and if so which kind. It watches two request sources. The first is a non-maskable input that arrives asynchronously to the clock. It is synchronized, filtered for a minimum high time and caught as a rising edge. That edge is then held pending until it is taken. The second is a level-sensitive external request. It is registered on every rising clock edge and honoured only while the interrupt-enable flag is set.

When the sequencer strobes `boundary`, the arbiter issues a single-cycle start pulse. A non-maskable start always carries vector type 2. An external start tells the sequencer to run the acknowledge cycles that fetch the type from the interrupt controller. The arbiter owns the enable flag. Any taken interrupt clears it, and so does a software interrupt or a single-step trap reported by the sequencer. A restore input reloads the flag when the saved flags are popped. A halt-exit output tells the sequencer to leave the halt state.

Top module: `intArbiter`

## Requirements
- R1: While `rstN` is low, `startNmi`, `startExt` and `ieFlag` are 0 and `haltExit` is 1.
- R2: A non-maskable request qualifies only if `nmiAsync` is sampled high on at least 3 consecutive rising edges. A pulse sampled high on 2 edges or fewer never produces a start.
- R3: A pending non-maskable request is taken at the next `boundary` whatever `ieFlag` is. `startNmi` is high for the one cycle after the `boundary` edge. It has priority over the external request, and `startNmi` and `startExt` are never high together.
- R4: `vecType` equals 2 in a cycle with `startNmi` high, and 0 in every other cycle.
- R5: `startExt` pulses for one cycle after a `boundary` edge only when all of the following hold: no non-maskable request is pending, `ieFlag` is 1, and `intrReq` was sampled high on the edge before the boundary edge.
- R6: An `intrReq` held high is taken again at each later boundary, for as long as the enable flag has been set again.
- R7: `ieFlag` becomes 0 on the edge that issues any start, and on any edge with `swIntTaken` high. A clear wins over a simultaneous restore.
- R8: A qualifying non-maskable edge that arrives after an earlier one has been taken is held and produces a second `startNmi`. Edges that qualify while a request is already pending merge into one start.
- R9: With `rstN` high, `haltExit` is 1 exactly when a non-maskable request is pending, or when the sampled `intrReq` is 1 and `ieFlag` is 1.
- R10: When nothing clears the flag, `flagRestore` high loads `flagRestoreVal` into `ieFlag` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiAsync | input | 1 | Non-maskable request, asynchronous to `clk` |
| intrReq | input | 1 | Level-sensitive external interrupt request |
| boundary | input | 1 | Instruction-boundary strobe from the sequencer |
| swIntTaken | input | 1 | Software interrupt or single-step trap being entered |
| flagRestore | input | 1 | Reload the enable flag from popped flags |
| flagRestoreVal | input | 1 | Value to reload into the enable flag |
| startNmi | output | 1 | One-cycle start of a non-maskable response |
| startExt | output | 1 | One-cycle start of an acknowledged external response |
| vecType | output | 8 | Vector type for a non-maskable start (2), else 0 |
| ieFlag | output | 1 | Current interrupt-enable flag |
| haltExit | output | 1 | Request to leave the halt state |

## Verification
A wrong filter count or a stale pending latch shows up first on `haltExit`. That signal reflects the pending state in the cycle after the qualifying edge, well before any boundary. A wrong decision or a wrong flag update appears on `startNmi`, `startExt` or `ieFlag` in the cycle right after the offending boundary or strobe edge. Because the bench compares every output on every clock against its own behavioural model, a fault is reported within one cycle of the point where it becomes observable.

// File: rtl/intArbPkg.sv
package intArbPkg;
  typedef struct packed {
    logic takeNmi;
    logic takeExt;
    logic clearIe;
    logic loadIe;
  } ctrlStrobes_t;
endpackage

// File: rtl/intArbDatapath.sv
module intArbDatapath
  import intArbPkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int NMI_MIN_HIGH = 3,
  parameter int TYPE_W       = 8,
  parameter int NMI_TYPE     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiAsync,
  input  logic              intrReq,
  input  logic              flagRestoreVal,
  input  ctrlStrobes_t      strobes,
  output logic              nmiPending,
  output logic              intrSampled,
  output logic              ieFlag,
  output logic              startNmi,
  output logic              startExt,
  output logic [TYPE_W-1:0] vecType
);
  localparam int CNT_W = $clog2(NMI_MIN_HIGH + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NMI_MIN_HIGH - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(NMI_MIN_HIGH);

  // synchronizer chain, one flop per stage
  logic [SYNC_STAGES-1:0] syncReg;
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[g] <= 1'b0;
          else       syncReg[g] <= nmiAsync;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[g] <= 1'b0;
          else       syncReg[g] <= syncReg[g-1];
        end
      end
    end
  endgenerate

  logic nmiSync;
  assign nmiSync = syncReg[SYNC_STAGES-1];

  // consecutive-high counter, saturating; qualifies once per high period
  logic [CNT_W-1:0] hiCnt;
  logic             nmiQualify;
  assign nmiQualify = nmiSync && (hiCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              hiCnt <= '0;
    else if (!nmiSync)      hiCnt <= '0;
    else if (hiCnt != CNT_SAT) hiCnt <= hiCnt + 1'b1;
  end

  // pending latch: a new qualifying edge wins over the service clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                nmiPending <= 1'b0;
    else if (nmiQualify)      nmiPending <= 1'b1;
    else if (strobes.takeNmi) nmiPending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intrSampled <= 1'b0;
    else       intrSampled <= intrReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ieFlag <= 1'b0;
    else if (strobes.clearIe) ieFlag <= 1'b0;
    else if (strobes.loadIe)  ieFlag <= flagRestoreVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startNmi <= 1'b0;
      startExt <= 1'b0;
      vecType  <= '0;
    end else begin
      startNmi <= strobes.takeNmi;
      startExt <= strobes.takeExt;
      vecType  <= strobes.takeNmi ? TYPE_W'(NMI_TYPE) : '0;
    end
  end
endmodule

// File: rtl/intArbControl.sv
module intArbControl
  import intArbPkg::*;
(
  input  logic         boundary,
  input  logic         swIntTaken,
  input  logic         flagRestore,
  input  logic         nmiPending,
  input  logic         intrSampled,
  input  logic         ieFlag,
  output ctrlStrobes_t strobes,
  output logic         wakeReq
);
  logic extEligible;
  assign extEligible = intrSampled && ieFlag;

  always_comb begin
    strobes = '0;
    if (boundary) begin
      if (nmiPending)       strobes.takeNmi = 1'b1;
      else if (extEligible) strobes.takeExt = 1'b1;
    end
    strobes.clearIe = strobes.takeNmi || strobes.takeExt || swIntTaken;
    strobes.loadIe  = flagRestore;
  end

  assign wakeReq = nmiPending || extEligible;
endmodule

// File: rtl/intArbiter.sv
module intArbiter
  import intArbPkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int NMI_MIN_HIGH = 3,
  parameter int TYPE_W       = 8,
  parameter int NMI_TYPE     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiAsync,
  input  logic              intrReq,
  input  logic              boundary,
  input  logic              swIntTaken,
  input  logic              flagRestore,
  input  logic              flagRestoreVal,
  output logic              startNmi,
  output logic              startExt,
  output logic [TYPE_W-1:0] vecType,
  output logic              ieFlag,
  output logic              haltExit
);
  ctrlStrobes_t strobes;
  logic nmiPending, intrSampled, wakeReq;

  intArbDatapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .NMI_MIN_HIGH(NMI_MIN_HIGH),
    .TYPE_W      (TYPE_W),
    .NMI_TYPE    (NMI_TYPE)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .nmiAsync      (nmiAsync),
    .intrReq       (intrReq),
    .flagRestoreVal(flagRestoreVal),
    .strobes       (strobes),
    .nmiPending    (nmiPending),
    .intrSampled   (intrSampled),
    .ieFlag        (ieFlag),
    .startNmi      (startNmi),
    .startExt      (startExt),
    .vecType       (vecType)
  );

  intArbControl u_ctrl (
    .boundary   (boundary),
    .swIntTaken (swIntTaken),
    .flagRestore(flagRestore),
    .nmiPending (nmiPending),
    .intrSampled(intrSampled),
    .ieFlag     (ieFlag),
    .strobes    (strobes),
    .wakeReq    (wakeReq)
  );

  assign haltExit = wakeReq || !rstN;
endmodule

// File: rtl/intArbiterChecker.sv
module intArbiterChecker #(
  parameter int TYPE_W   = 8,
  parameter int NMI_TYPE = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              boundary,
  input logic              swIntTaken,
  input logic              startNmi,
  input logic              startExt,
  input logic [TYPE_W-1:0] vecType,
  input logic              ieFlag,
  input logic              haltExit
);
  always_comb begin
    if (!rstN) assert_reset_halt_R1: assert (haltExit);
  end

  assert_exclusive_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(startNmi && startExt));

  assert_start_on_boundary_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startNmi || startExt) |-> $past(boundary));

  assert_nmi_type_R4: assert property (@(posedge clk) disable iff (!rstN)
    startNmi |-> (vecType == TYPE_W'(NMI_TYPE)));

  assert_idle_type_R4: assert property (@(posedge clk) disable iff (!rstN)
    !startNmi |-> (vecType == '0));

  assert_ext_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    startExt |-> $past(ieFlag));

  assert_flag_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    (startNmi || startExt) |-> !ieFlag);

  assert_swint_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    swIntTaken |=> !ieFlag);
endmodule

bind intArbiter intArbiterChecker #(
  .TYPE_W  (TYPE_W),
  .NMI_TYPE(NMI_TYPE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .boundary  (boundary),
  .swIntTaken(swIntTaken),
  .startNmi  (startNmi),
  .startExt  (startExt),
  .vecType   (vecType),
  .ieFlag    (ieFlag),
  .haltExit  (haltExit)
);

// File: tb/intArbiter_tb.sv
`timescale 1ns/1ps
module intArbiter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiAsync = 0, intrReq = 0, boundary = 0, swIntTaken = 0;
  logic flagRestore = 0, flagRestoreVal = 0;
  logic startNmi, startExt, ieFlag, haltExit;
  logic [7:0] vecType;

  always #2 clk = ~clk;

  intArbiter u_dut (
    .clk(clk), .rstN(rstN), .nmiAsync(nmiAsync), .intrReq(intrReq),
    .boundary(boundary), .swIntTaken(swIntTaken), .flagRestore(flagRestore),
    .flagRestoreVal(flagRestoreVal), .startNmi(startNmi), .startExt(startExt),
    .vecType(vecType), .ieFlag(ieFlag), .haltExit(haltExit)
  );

  int checks = 0, fails = 0;
  int nmiSeen = 0, extSeen = 0;
  bit done = 0;

  // behavioural reference model
  bit nmiHist[$];
  int runLen = 0;
  bit mPend = 0, mLastIntr = 0, mIe = 0, mStartNmi = 0, mStartExt = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      nmiHist.delete();
      runLen = 0; mPend = 0; mLastIntr = 0; mIe = 0;
      mStartNmi = 0; mStartExt = 0;
    end else begin
      bit seen, qual, tn, te;
      nmiHist.push_back(nmiAsync);
      seen = (nmiHist.size() >= 3) ? nmiHist[nmiHist.size()-3] : 1'b0;
      if (nmiHist.size() > 8) void'(nmiHist.pop_front());
      runLen = seen ? runLen + 1 : 0;
      qual = (runLen == 3);
      tn = boundary && mPend;
      te = boundary && !mPend && mLastIntr && mIe;
      mPend = qual || (mPend && !tn);
      if (tn || te || swIntTaken) mIe = 0;
      else if (flagRestore) mIe = flagRestoreVal;
      mStartNmi = tn; mStartExt = te;
      mLastIntr = intrReq;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rstN) begin
        check("R1 startNmi in reset", startNmi, 0);
        check("R1 startExt in reset", startExt, 0);
        check("R1 ieFlag in reset", ieFlag, 0);
        check("R1 haltExit in reset", haltExit, 1);
      end else begin
        check("R3/R8 startNmi", startNmi, mStartNmi);
        check("R5/R6 startExt", startExt, mStartExt);
        check("R4 vecType", vecType, mStartNmi ? 8'd2 : 8'd0);
        check("R7/R10 ieFlag", ieFlag, mIe);
        check("R9 haltExit", haltExit, mPend || (mLastIntr && mIe));
        if (startNmi) nmiSeen++;
        if (startExt) extSeen++;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseBoundary();
    boundary = 1; step(1); boundary = 0;
  endtask

  task automatic restoreIe(input logic v);
    flagRestore = 1; flagRestoreVal = v; step(1); flagRestore = 0;
  endtask

  task automatic nmiPulse(input int highCycles);
    nmiAsync = 1; step(highCycles); nmiAsync = 0;
  endtask

  initial begin
    int n0, e0;
    step(3);
    rstN = 1;
    step(2);

    // R10 restore, then R5/R6 repeated external service
    restoreIe(1);
    check("R10 ieFlag after restore", ieFlag, 1);
    intrReq = 1; step(2);
    e0 = extSeen;
    pulseBoundary(); step(1);
    restoreIe(1); step(1);
    pulseBoundary(); step(2);
    check("R6 held intrReq served twice", 8'(extSeen - e0), 2);

    // R7 software interrupt clears flag, and wins over restore
    restoreIe(1);
    swIntTaken = 1; flagRestore = 1; flagRestoreVal = 1; step(1);
    swIntTaken = 0; flagRestore = 0;
    check("R7 swInt beats restore", ieFlag, 0);
    e0 = extSeen;
    pulseBoundary(); step(2);
    check("R5 no external start when disabled", 8'(extSeen - e0), 0);
    intrReq = 0; step(2);

    // R2 short pulse ignored
    n0 = nmiSeen;
    nmiPulse(2); step(6);
    pulseBoundary(); step(2);
    check("R2 two-cycle NMI pulse ignored", 8'(nmiSeen - n0), 0);

    // R3 NMI taken with flag clear, and priority over intr
    restoreIe(1); intrReq = 1;
    n0 = nmiSeen; e0 = extSeen;
    nmiPulse(4); step(4);
    check("R9 haltExit with pending NMI", haltExit, 1);
    pulseBoundary(); step(2);
    check("R3 NMI wins over intr", 8'(nmiSeen - n0), 1);
    check("R3 no ext alongside NMI", 8'(extSeen - e0), 0);
    intrReq = 0; step(2);

    // R8 merged edges then a fresh edge after service
    n0 = nmiSeen;
    nmiPulse(3); step(2); nmiPulse(3); step(6);
    pulseBoundary(); step(2);
    pulseBoundary(); step(2);
    check("R8 merged edges give one start", 8'(nmiSeen - n0), 1);
    nmiPulse(5); step(6);
    pulseBoundary(); step(2);
    check("R8 second edge gives second start", 8'(nmiSeen - n0), 2);

    // R1 reset during activity
    nmiPulse(4);
    rstN = 0; step(2);
    rstN = 1; step(4);
    check("R1 pending cleared by reset", haltExit, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule